// File: doc/BRIEF.md
# Message-Signalled Interrupt Capability with Per-Vector Masking

This block holds a message-signalled interrupt capability structure as it appears in a device's configuration space. It also turns edges on the device's interrupt request lines into memory-write messages. Software programs a target address, a data pattern, an enable bit and a count of enabled messages through a byte-wide write port, and reads any dword of the structure back through a read port.

Each request line carries the vector number equal to its bit index. On a rising edge, the request is either held as pending because its mask bit is set, or queued as an outgoing message. Each message carries a 64-bit address and a 32-bit data word, and leaves through a valid/ready handshake. When a configuration write clears a mask bit while a request for that vector is pending, the message goes out at once.

Parameters select the number of vectors (1 to 32), the 64-bit address variant, and whether masking exists. The register offsets follow the chosen variant.

Top module: `msi_cap`

## Requirements
- R1: Byte 0 reads as capability ID 0x05 and byte 1 reads as the NEXT_PTR parameter. Writes to either byte are ignored.
- R2: In the low byte of message control, the writable bits are bit 0 (enable) and bits 6:4 (enabled-message count as a power of two). Bits 3:1 show the capable count and bit 7 shows the 64-bit flag, and writes do not change them.
- R3: The high byte of message control ignores writes. Bit 8 reads 1 only when masking is supported, and bits 15:9 read 0.
- R4: The capable count is the smallest k with 2^k at least NVEC. With NVEC=8 it reads 3. An NVEC outside 1..32 is an elaboration error.
- R5: The layout depends on the variant. The 64-bit variant has address-low at byte 4, address-high at 8, data at 12, mask at 16 and pending at 20, and messages carry {address-high, address-low}. The 32-bit variant has address at 4, data at 8, mask at 12 and pending at 16, and the upper address half is zero. Only the low 16 data bits are stored, and the upper data bytes read 0.
- R6: The data word sent for vector v is the programmed data with its low m bits replaced by the low m bits of v, where m is the enabled count field. Bits 31:16 are zero.
- R7: A request acts only on its 0-to-1 transition. A line held high produces one event.
- R8: A request whose mask bit is set only sets its pending bit. An unmasked request queues a message and clears that vector's pending bit.
- R9: While enabled, a mask-register byte write that turns a mask bit from 1 to 0 queues that vector's message if it is pending, and clears the pending bit. While disabled, the pending bit is kept and no message is sent.
- R10: The mask and pending registers reset to zero. Configuration writes to the pending register have no effect.
- R11: Queued messages leave in ascending vector order. No request is lost while the output is stalled, and a vector has at most one queued message.
- R12: While the enable bit is clear, no message is presented. Queued messages are dropped, and new requests are discarded.
- R13: While enabled and not being written, a presented message stays valid until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Byte write strobe |
| cfg_addr | input | 5 | Byte offset within the capability |
| cfg_wdata | input | 8 | Byte to write |
| rd_idx | input | 3 | Dword index to read |
| rd_data | output | 32 | Selected dword, combinational |
| irq | input | NVEC | Interrupt requests, bit index is the vector |
| msg_valid | output | 1 | Message presented |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The hold-until-accepted property assumes that the enable bit is not rewritten while a message is stalled. It is excused on any cycle that carries a configuration write, because disabling the block is allowed to withdraw a message. The pending and unmask properties assume the request lines are sampled synchronously. The stimulus changes inputs only just after a rising edge, and it stalls the output only across stretches in which it writes nothing, except in the one case that deliberately disables the block under stall.

// File: rtl/msi_cap.sv
module msi_cap #(
  parameter int       NVEC     = 8,
  parameter bit       IS64     = 1'b1,
  parameter bit       MASKING  = 1'b1,
  parameter bit [7:0] NEXT_PTR = 8'h40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [4:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic [2:0]      rd_idx,
  output logic [31:0]     rd_data,
  input  logic [NVEC-1:0] irq,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [63:0]     msg_addr,
  output logic [31:0]     msg_data
);
  localparam int         OFF_DATA = IS64 ? 12 : 8;
  localparam int         OFF_MASK = IS64 ? 16 : 12;
  localparam int         OFF_PEND = IS64 ? 20 : 16;
  localparam bit [2:0]   MMC      = 3'($clog2(NVEC));
  localparam bit [31:0]  VMASK    = 32'hFFFF_FFFF >> (32 - NVEC);

  if (NVEC < 1 || NVEC > 32) begin : g_bad_nvec
    $error("msi_cap: NVEC must be within 1..32");
  end

  logic            en_q;
  logic [2:0]      mme_q;
  logic [31:0]     addr_lo, addr_hi;
  logic [15:0]     data_q;
  logic [31:0]     mask_q, pend_q, outq;
  logic [NVEC-1:0] irq_q;

  logic [31:0] mask_nx, pend_nx, outq_nx, rise, req, held, direct, unmask, gnt;
  logic [4:0]  sel;
  logic [15:0] mme_m;
  logic [15:0] ctrl;

  wire wr_ctl = cfg_we && cfg_addr == 5'd2;
  wire wr_alo = cfg_we && cfg_addr[4:2] == 3'd1;
  wire wr_ahi = cfg_we && IS64 && cfg_addr[4:2] == 3'd2;
  wire wr_dat = cfg_we && cfg_addr[4:1] == 4'(OFF_DATA / 2);
  wire wr_msk = cfg_we && MASKING && cfg_addr[4:2] == 3'(OFF_MASK / 4);

  assign rise = 32'(irq & ~irq_q);
  assign req  = en_q ? rise : 32'd0;

  always_comb begin
    mask_nx = mask_q;
    if (wr_msk) mask_nx[{cfg_addr[1:0], 3'b000} +: 8] = cfg_wdata;
    mask_nx = MASKING ? (mask_nx & VMASK) : 32'd0;
  end

  always_comb begin
    sel = 5'd0;
    for (int i = 31; i >= 0; i--)
      if (outq[i]) sel = 5'(i);
  end

  assign msg_valid = en_q && (|outq);
  assign gnt     = (msg_valid && msg_ready) ? (32'd1 << sel) : 32'd0;
  assign unmask  = en_q ? (mask_q & ~mask_nx & pend_q) : 32'd0;
  assign held    = req & mask_nx;
  assign direct  = req & ~mask_nx;
  assign pend_nx = MASKING ? ((pend_q | held) & ~direct & ~unmask) : 32'd0;
  assign outq_nx = en_q ? ((outq & ~gnt) | direct | unmask) : 32'd0;

  assign mme_m    = ~(16'hFFFF << mme_q);
  assign msg_addr = {addr_hi, addr_lo};
  assign msg_data = {16'h0, (data_q & ~mme_m) | (16'(sel) & mme_m)};

  assign ctrl = {7'd0, MASKING, IS64, mme_q, MMC, en_q};

  always_comb begin
    if (rd_idx == 3'd0)                    rd_data = {ctrl, NEXT_PTR, 8'h05};
    else if (rd_idx == 3'd1)               rd_data = addr_lo;
    else if (IS64 && rd_idx == 3'd2)       rd_data = addr_hi;
    else if (rd_idx == 3'(OFF_DATA / 4))   rd_data = {16'h0, data_q};
    else if (rd_idx == 3'(OFF_MASK / 4))   rd_data = mask_q;
    else if (rd_idx == 3'(OFF_PEND / 4))   rd_data = pend_q;
    else                                   rd_data = 32'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mme_q   <= 3'd0;
      addr_lo <= 32'd0;
      addr_hi <= 32'd0;
      data_q  <= 16'd0;
      mask_q  <= 32'd0;
      pend_q  <= 32'd0;
      outq    <= 32'd0;
      irq_q   <= '0;
    end else begin
      irq_q  <= irq;
      mask_q <= mask_nx;
      pend_q <= pend_nx;
      outq   <= outq_nx;
      if (wr_ctl) begin
        en_q  <= cfg_wdata[0];
        mme_q <= cfg_wdata[6:4];
      end
      if (wr_alo) addr_lo[{cfg_addr[1:0], 3'b000} +: 8] <= cfg_wdata;
      if (wr_ahi) addr_hi[{cfg_addr[1:0], 3'b000} +: 8] <= cfg_wdata;
      if (wr_dat) data_q[{cfg_addr[0], 3'b000} +: 8] <= cfg_wdata;
    end
  end
endmodule

module msi_cap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        cfg_we,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [31:0] mask,
  input logic [31:0] pend
);
  a_r13_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready && en && !cfg_we) |=> msg_valid);

  a_r8_pend_only_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~mask) == 32'd0));

  a_r9_unmask_drains: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> ((pend & $past(mask) & ~mask) == 32'd0));

  a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !msg_valid);
endmodule

bind msi_cap msi_cap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .cfg_we(cfg_we),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .mask(mask_q), .pend(pend_q)
);

// File: tb/sim_msi_cap.sv
module sim_msi_cap;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [7:0]  irq = '0;
  logic        msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  msi_cap #(.NVEC(8), .IS64(1'b1), .MASKING(1'b1), .NEXT_PTR(8'h40)) u0 (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .rd_idx, .rd_data,
    .irq, .msg_valid, .msg_ready, .msg_addr, .msg_data);

  always #4 clk = ~clk;

  localparam logic [63:0] ADDR = 64'h0000_0001_FEE0_1000;
  logic [95:0] exp_q[$];
  int n_chk = 0, n_fail = 0;
  string tag = "R6";
  bit done = 0;

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfgw(logic [4:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic rdchk(logic [2:0] idx, logic [31:0] exp, string req);
    rd_idx = idx;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic pulse(logic [7:0] m);
    irq = irq | m;
    tick(1);
    irq = irq & ~m;
  endtask

  task automatic expect_msg(logic [31:0] d);
    exp_q.push_back({ADDR, d});
  endtask

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL %s: unexpected message data %h, expected none", tag, msg_data);
      end else begin
        logic [95:0] e;
        e = exp_q.pop_front();
        check(tag, msg_addr, e[95:32]);
        check(tag, {32'd0, msg_data}, {32'd0, e[31:0]});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    rdchk(3'd0, 32'h0186_4005, "R1 R3 R4 reset");
    rdchk(3'd4, 32'd0, "R10 mask reset");
    rdchk(3'd5, 32'd0, "R10 pending reset");

    cfgw(5'd0, 8'hFF); cfgw(5'd1, 8'hFF);
    rdchk(3'd0, 32'h0186_4005, "R1 ro bytes");
    cfgw(5'd3, 8'hFF);
    rdchk(3'd0, 32'h0186_4005, "R3 high ctrl");
    cfgw(5'd2, 8'hFF);
    rdchk(3'd0, 32'h01F7_4005, "R2 ctrl low");
    cfgw(5'd2, 8'h21);
    rdchk(3'd0, 32'h01A7_4005, "R2 mme=2 en");

    cfgw(5'd4, 8'h00); cfgw(5'd5, 8'h10); cfgw(5'd6, 8'hE0); cfgw(5'd7, 8'hFE);
    cfgw(5'd8, 8'h01); cfgw(5'd9, 8'h00); cfgw(5'd10, 8'h00); cfgw(5'd11, 8'h00);
    cfgw(5'd12, 8'h67); cfgw(5'd13, 8'h45); cfgw(5'd14, 8'hAA); cfgw(5'd15, 8'hAA);
    rdchk(3'd1, 32'hFEE0_1000, "R5 addr lo");
    rdchk(3'd2, 32'h0000_0001, "R5 addr hi");
    rdchk(3'd3, 32'h0000_4567, "R5 data");

    tag = "R7 R6 vec5";
    expect_msg(32'h4565);
    irq[5] = 1'b1; tick(6); irq[5] = 1'b0; tick(4);
    check("R7 single event", exp_q.size(), 0);

    tag = "R11 order";
    msg_ready = 1'b0;
    expect_msg(32'h4565); expect_msg(32'h4567); expect_msg(32'h4566);
    pulse(8'h4A); tick(1);
    pulse(8'h02); tick(3);
    check("R13 held under stall", msg_valid, 1);
    msg_ready = 1'b1; tick(6);
    check("R11 drained", exp_q.size(), 0);

    tag = "R8 masked";
    cfgw(5'd16, 8'h04);
    pulse(8'h04); tick(3);
    rdchk(3'd5, 32'h4, "R8 pending set");
    cfgw(5'd20, 8'h00); tick(1);
    rdchk(3'd5, 32'h4, "R10 pending ro");
    tag = "R9 unmask";
    expect_msg(32'h4566);
    cfgw(5'd16, 8'h00); tick(3);
    rdchk(3'd5, 32'h0, "R9 pending cleared");
    check("R9 fired", exp_q.size(), 0);

    tag = "R12 disabled";
    cfgw(5'd16, 8'h01);
    pulse(8'h01); tick(1);
    cfgw(5'd2, 8'h20);
    cfgw(5'd16, 8'h00); tick(1);
    rdchk(3'd5, 32'h1, "R9 kept while disabled");
    pulse(8'h10);
    cfgw(5'd2, 8'h21); tick(3);
    rdchk(3'd5, 32'h1, "R9 no refire on enable");
    tag = "R8 unmasked clears";
    expect_msg(32'h4564);
    pulse(8'h01); tick(3);
    rdchk(3'd5, 32'h0, "R8 pending cleared by request");

    tag = "R12 flush";
    msg_ready = 1'b0;
    pulse(8'h80); tick(2);
    cfgw(5'd2, 8'h20);
    tick(1);
    check("R12 no valid disabled", msg_valid, 0);
    msg_ready = 1'b1;
    cfgw(5'd2, 8'h21); tick(4);
    check("R12 flushed", msg_valid, 0);

    tag = "R6 mme0";
    cfgw(5'd2, 8'h01);
    expect_msg(32'h4567);
    pulse(8'h80); tick(10);
    check("R11 no loss", exp_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule